// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block tracks which of 256 interrupt vectors are waiting and which are being serviced. It holds two vector sets, a request set and an in-service set. Each set is stored as eight 32-bit words, and software-facing logic reads them one word at a time. Commands set or clear a single request vector by number. An acknowledge moves the highest waiting request into service, and an end-of-interrupt retires the highest vector in service. The block always shows the highest vector of each set. A delivery-ready flag rises when the waiting request belongs to a higher priority class than the work already in service.

Five special interrupt kinds never enter the request set. Each has its own pending flag and a captured vector. The kinds are system management, non-maskable, external, init and startup. A summary flag covers every special kind except external. A saturating counter tracks interprocessor interrupts that have been sent but not yet completed.

Top module: `irq_tracker`

## Requirements
- R1: After reset, both sets are empty, both top vectors read 0, the deliver, summary and pending outputs are 0, and the interprocessor count is 0.
- R2: A set or clear command on vector v writes word v/32, bit v mod 32, of the request set. The change is visible one cycle later. `rd_sel_i`=0 reads the request set and `rd_sel_i`=1 reads the in-service set, at word `rd_word_i`.
- R3: When a set and a clear of the same vector arrive in the same cycle, the set wins and the bit ends up 1.
- R4: Each top vector is the highest set bit of its set, searched from word 7 down to word 0. An empty set gives 0.
- R5: An acknowledge clears the top request bit and sets the same vector in the in-service set in the same cycle. This also works for vector 0. An acknowledge with an empty request set changes nothing.
- R6: An end-of-interrupt clears the highest in-service bit. With an empty in-service set it changes nothing.
- R7: `deliver_o` is 1 exactly when the request set is not empty and bits 7:4 of the top request exceed bits 7:4 of the top in-service vector.
- R8: Special kinds use bit positions 0 SMI, 1 NMI, 2 external, 3 init and 4 startup. A raise sets the pending bit and captures `sb_vec_i` into byte k of `sb_vec_o`. A take clears the pending bit, and a raise in the same cycle wins over the take. Raises never touch the request set.
- R9: `urgent_o` is 1 when any special kind other than external (bit 2) is pending.
- R10: The interprocessor count rises on a send and falls on a done. It does not change when both arrive together. It saturates at 0 and at its maximum (7 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 1 | Set request vector |
| req_set_vec_i | input | 8 | Vector to set |
| req_clr_i | input | 1 | Clear request vector |
| req_clr_vec_i | input | 8 | Vector to clear |
| ack_i | input | 1 | Move top request into service |
| eoi_i | input | 1 | Retire top in-service vector |
| rd_sel_i | input | 1 | Read set select: 0 request, 1 in-service |
| rd_word_i | input | 3 | Word index to read |
| rd_data_o | output | 32 | Selected word |
| top_req_o | output | 8 | Highest request vector |
| top_isr_o | output | 8 | Highest in-service vector |
| deliver_o | output | 1 | Top request outranks service class |
| sb_raise_i | input | 5 | Raise special kind, one bit per kind |
| sb_vec_i | input | 8 | Vector captured on a raise |
| sb_take_i | input | 5 | Clear special pending flag |
| sb_pend_o | output | 5 | Special pending flags |
| sb_vec_o | output | 40 | Captured vectors, byte k for kind k |
| urgent_o | output | 1 | Any non-external special kind pending |
| ipi_send_i | input | 1 | Interprocessor interrupt sent |
| ipi_done_i | input | 1 | Interprocessor interrupt completed |
| ipi_cnt_o | output | 3 | Interprocessor interrupts in flight |

## Verification
The assertions check four rules on every cycle:
- a set bit lands where it should, and wins over a clear of the same vector;
- a clear removes its bit, and the search result always points at a set bit or is 0 for an empty set;
- an acknowledge places its vector in service, and an end-of-interrupt retires its vector;
- a raise captures its vector, and the counter steps by exactly one.

Other behaviour depends on ordered sequences, so only the bench scenarios can show it. These include the top-down search over scattered vectors, the class comparison behind `deliver_o`, and the exclusion of external from the summary flag. They also include acknowledge and end-of-interrupt on empty sets, and saturation at both ends of the count.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_NUM  = 256;
  localparam int WORD_BITS = 32;
  localparam int SB_NUM   = 5;
  typedef enum logic [2:0] {
    SB_SMI   = 3'd0,
    SB_NMI   = 3'd1,
    SB_EXT   = 3'd2,
    SB_INIT  = 3'd3,
    SB_START = 3'd4
  } sb_kind_e;
  localparam logic [SB_NUM-1:0] SB_URGENT_MASK = 5'b11011;
endpackage

// File: rtl/irq_top_find.sv
module irq_top_find #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int VEC_W    = $clog2(WORD_W * NUM_WORDS)
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  output logic                             any_o,
  output logic [VEC_W-1:0]                 top_o
);
  // later (higher) words and bits overwrite, so the top-most set bit wins
  always_comb begin
    any_o = 1'b0;
    top_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (|words_i[w]) begin
        any_o = 1'b1;
        for (int b = 0; b < WORD_W; b++) begin
          if (words_i[w][b]) top_o = VEC_W'(w * WORD_W + b);
        end
      end
    end
  end

  logic [NUM_WORDS*WORD_W-1:0] flat;
  assign flat = words_i;

  always_comb begin
    // R4
    top_bit_set_chk: assert (!any_o || flat[top_o]);
    // R4
    empty_zero_chk: assert (any_o || top_o == '0);
  end
endmodule

// File: rtl/irq_vec_set.sv
module irq_vec_set #(
  parameter int NUM_VEC  = 256,
  parameter int WORD_W   = 32,
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int BIT_W   = $clog2(WORD_W),
  localparam int WIDX_W  = VEC_W - BIT_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             set_i,
  input  logic [VEC_W-1:0]                 set_vec_i,
  input  logic                             clr_a_i,
  input  logic [VEC_W-1:0]                 clr_a_vec_i,
  input  logic                             clr_b_i,
  input  logic [VEC_W-1:0]                 clr_b_vec_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o,
  output logic                             any_o,
  output logic [VEC_W-1:0]                 top_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] set_m, clr_m;
    always_comb begin
      set_m = '0;
      clr_m = '0;
      if (set_i && set_vec_i[VEC_W-1:BIT_W] == WIDX_W'(w))
        set_m = WORD_W'(1) << set_vec_i[BIT_W-1:0];
      if (clr_a_i && clr_a_vec_i[VEC_W-1:BIT_W] == WIDX_W'(w))
        clr_m = clr_m | (WORD_W'(1) << clr_a_vec_i[BIT_W-1:0]);
      if (clr_b_i && clr_b_vec_i[VEC_W-1:BIT_W] == WIDX_W'(w))
        clr_m = clr_m | (WORD_W'(1) << clr_b_vec_i[BIT_W-1:0]);
    end
    // set applied after clear: set wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) words_o[w] <= '0;
      else         words_o[w] <= (words_o[w] & ~clr_m) | set_m;
    end
  end

  irq_top_find #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_find (
    .words_i(words_o),
    .any_o  (any_o),
    .top_o  (top_o)
  );

  logic [NUM_VEC-1:0] flat;
  assign flat = words_o;

  // R3
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flat[$past(set_vec_i)]);
  // R2
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && !(set_i && set_vec_i == clr_a_vec_i)) |=> !flat[$past(clr_a_vec_i)]);
endmodule

// File: rtl/irq_side_band.sv
module irq_side_band #(
  parameter int NUM_SB = 5,
  parameter int VEC_W  = 8,
  parameter logic [NUM_SB-1:0] URGENT_MASK = irq_pkg::SB_URGENT_MASK
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SB-1:0]            raise_i,
  input  logic [VEC_W-1:0]             vec_i,
  input  logic [NUM_SB-1:0]            take_i,
  output logic [NUM_SB-1:0]            pend_o,
  output logic [NUM_SB-1:0][VEC_W-1:0] vec_o,
  output logic                         urgent_o
);
  for (genvar k = 0; k < NUM_SB; k++) begin : g_kind
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[k] <= 1'b0;
        vec_o[k]  <= '0;
      end else if (raise_i[k]) begin
        pend_o[k] <= 1'b1;
        vec_o[k]  <= vec_i;
      end else if (take_i[k]) begin
        pend_o[k] <= 1'b0;
      end
    end
    // R8
    raise_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise_i[k] |=> (pend_o[k] && vec_o[k] == $past(vec_i)));
  end

  assign urgent_o = |(pend_o & URGENT_MASK);
endmodule

// File: rtl/irq_ipi_count.sv
module irq_ipi_count #(
  parameter int CNT_W = 3,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else begin
      unique case ({send_i, done_i})
        2'b10:   if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
        2'b01:   if (cnt_o != '0)      cnt_o <= cnt_o - CNT_W'(1);
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  // R10
  cnt_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !done_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R10
  cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !send_i && cnt_o == '0) |=> cnt_o == '0);
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker #(
  parameter int NUM_VEC = irq_pkg::VEC_NUM,
  parameter int WORD_W  = irq_pkg::WORD_BITS,
  parameter int CLASS_W = 4,
  parameter int IPI_W   = 3,
  parameter int NUM_SB  = irq_pkg::SB_NUM,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WIDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_set_i,
  input  logic [VEC_W-1:0]        req_set_vec_i,
  input  logic                    req_clr_i,
  input  logic [VEC_W-1:0]        req_clr_vec_i,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  input  logic                    rd_sel_i,
  input  logic [WIDX_W-1:0]       rd_word_i,
  output logic [WORD_W-1:0]       rd_data_o,
  output logic [VEC_W-1:0]        top_req_o,
  output logic [VEC_W-1:0]        top_isr_o,
  output logic                    deliver_o,
  input  logic [NUM_SB-1:0]       sb_raise_i,
  input  logic [VEC_W-1:0]        sb_vec_i,
  input  logic [NUM_SB-1:0]       sb_take_i,
  output logic [NUM_SB-1:0]       sb_pend_o,
  output logic [NUM_SB*VEC_W-1:0] sb_vec_o,
  output logic                    urgent_o,
  input  logic                    ipi_send_i,
  input  logic                    ipi_done_i,
  output logic [IPI_W-1:0]        ipi_cnt_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] req_words, isr_words;
  logic req_any, isr_any, ack_fire, eoi_fire;
  logic [NUM_SB-1:0][VEC_W-1:0] sb_vecs;

  assign ack_fire = ack_i & req_any;
  assign eoi_fire = eoi_i & isr_any;

  irq_vec_set #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req (
    .clk_i, .rst_ni,
    .set_i      (req_set_i),
    .set_vec_i  (req_set_vec_i),
    .clr_a_i    (req_clr_i),
    .clr_a_vec_i(req_clr_vec_i),
    .clr_b_i    (ack_fire),
    .clr_b_vec_i(top_req_o),
    .words_o    (req_words),
    .any_o      (req_any),
    .top_o      (top_req_o)
  );

  irq_vec_set #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk_i, .rst_ni,
    .set_i      (ack_fire),
    .set_vec_i  (top_req_o),
    .clr_a_i    (eoi_fire),
    .clr_a_vec_i(top_isr_o),
    .clr_b_i    (1'b0),
    .clr_b_vec_i('0),
    .words_o    (isr_words),
    .any_o      (isr_any),
    .top_o      (top_isr_o)
  );

  irq_side_band #(.NUM_SB(NUM_SB), .VEC_W(VEC_W)) u_sb (
    .clk_i, .rst_ni,
    .raise_i (sb_raise_i),
    .vec_i   (sb_vec_i),
    .take_i  (sb_take_i),
    .pend_o  (sb_pend_o),
    .vec_o   (sb_vecs),
    .urgent_o(urgent_o)
  );
  assign sb_vec_o = sb_vecs;

  irq_ipi_count #(.CNT_W(IPI_W)) u_ipi (
    .clk_i, .rst_ni,
    .send_i(ipi_send_i),
    .done_i(ipi_done_i),
    .cnt_o (ipi_cnt_o)
  );

  assign rd_data_o = rd_sel_i ? isr_words[rd_word_i] : req_words[rd_word_i];
  assign deliver_o = req_any &&
                     (top_req_o[VEC_W-1 -: CLASS_W] > top_isr_o[VEC_W-1 -: CLASS_W]);

  logic [NUM_VEC-1:0] isr_flat;
  assign isr_flat = isr_words;

  // R5
  ack_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> isr_flat[$past(top_req_o)]);
  // R6
  eoi_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_fire && !(ack_fire && top_req_o == top_isr_o)) |=> !isr_flat[$past(top_isr_o)]);
endmodule

// File: tb/irq_tracker_bench.sv
`timescale 1ns/1ps
module irq_tracker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_set = 0, req_clr = 0, ack = 0, eoi = 0, rd_sel = 0;
  logic [7:0] req_set_vec = 0, req_clr_vec = 0, sb_vec = 0;
  logic [2:0] rd_word = 0;
  logic [4:0] sb_raise = 0, sb_take = 0;
  logic ipi_send = 0, ipi_done = 0;
  logic [31:0] rd_data;
  logic [7:0] top_req, top_isr;
  logic deliver, urgent;
  logic [4:0] sb_pend;
  logic [39:0] sb_vec_out;
  logic [2:0] ipi_cnt;

  irq_tracker u_irq_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_set_i(req_set), .req_set_vec_i(req_set_vec),
    .req_clr_i(req_clr), .req_clr_vec_i(req_clr_vec),
    .ack_i(ack), .eoi_i(eoi),
    .rd_sel_i(rd_sel), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .top_req_o(top_req), .top_isr_o(top_isr), .deliver_o(deliver),
    .sb_raise_i(sb_raise), .sb_vec_i(sb_vec), .sb_take_i(sb_take),
    .sb_pend_o(sb_pend), .sb_vec_o(sb_vec_out), .urgent_o(urgent),
    .ipi_send_i(ipi_send), .ipi_done_i(ipi_done), .ipi_cnt_o(ipi_cnt)
  );

  typedef enum int {K_TREQ, K_TISR, K_DLV, K_URG, K_PEND, K_IPI, K_RD, K_EXTV, K_NMIV} kind_e;
  typedef struct { kind_e kind; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [31:0] observe(kind_e k);
    case (k)
      K_TREQ: return 32'(top_req);
      K_TISR: return 32'(top_isr);
      K_DLV:  return 32'(deliver);
      K_URG:  return 32'(urgent);
      K_PEND: return 32'(sb_pend);
      K_IPI:  return 32'(ipi_cnt);
      K_RD:   return rd_data;
      K_EXTV: return 32'(sb_vec_out[23:16]);
      default: return 32'(sb_vec_out[15:8]);
    endcase
  endfunction

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (observe(it.kind) !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, observe(it.kind), it.exp);
      end
    end
  end

  task automatic expect_v(kind_e k, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    req_set = 0; req_clr = 0; ack = 0; eoi = 0;
    sb_raise = 0; sb_take = 0; ipi_send = 0; ipi_done = 0;
  endtask

  task automatic rd(logic s, logic [2:0] w, logic [31:0] e, string t);
    rd_sel = s; rd_word = w;
    expect_v(K_RD, e, t);
    settle();
  endtask

  task automatic do_set(logic [7:0] v);
    req_set = 1; req_set_vec = v; tick();
  endtask

  task automatic do_clr(logic [7:0] v);
    req_clr = 1; req_clr_vec = v; tick();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_v(K_TREQ, 0, "R1 top_req"); expect_v(K_TISR, 0, "R1 top_isr");
    expect_v(K_DLV, 0, "R1 deliver"); expect_v(K_URG, 0, "R1 urgent");
    expect_v(K_PEND, 0, "R1 pend"); expect_v(K_IPI, 0, "R1 ipi");
    settle();
    rd(0, 7, 0, "R1 req word7");

    // R2 / R4 / R7 placement and search
    do_set(8'h45);
    expect_v(K_TREQ, 8'h45, "R4 top 45"); expect_v(K_DLV, 1, "R7 deliver class4 over empty");
    settle();
    rd(0, 2, 32'h20, "R2 word2 bit5");
    do_set(8'hE1);
    do_set(8'h1F);
    expect_v(K_TREQ, 8'hE1, "R4 top from word7");
    settle();
    rd(0, 0, 32'h8000_0000, "R2 word0 bit31");
    rd(0, 7, 32'h2, "R2 word7 bit1");
    do_clr(8'hE1);
    expect_v(K_TREQ, 8'h45, "R2 clear E1");
    settle();

    // R3 simultaneous set and clear
    req_set = 1; req_set_vec = 8'h80; req_clr = 1; req_clr_vec = 8'h80; tick();
    expect_v(K_TREQ, 8'h80, "R3 set wins top");
    settle();
    rd(0, 4, 32'h1, "R3 set wins word4");

    // R5 acknowledge
    ack = 1; tick();
    expect_v(K_TISR, 8'h80, "R5 isr top 80"); expect_v(K_TREQ, 8'h45, "R5 req top 45");
    expect_v(K_DLV, 0, "R7 class4 under class8");
    settle();
    rd(1, 4, 32'h1, "R5 isr word4");
    rd(0, 4, 32'h0, "R5 req word4 cleared");
    ack = 1; tick();
    expect_v(K_TISR, 8'h80, "R5 isr top stays 80"); expect_v(K_TREQ, 8'h1F, "R5 req top 1F");
    settle();
    rd(1, 2, 32'h20, "R5 isr word2");

    // R6 end of interrupt
    eoi = 1; tick();
    expect_v(K_TISR, 8'h45, "R6 isr top 45"); expect_v(K_DLV, 0, "R7 class1 under class4");
    settle();
    eoi = 1; tick();
    expect_v(K_TISR, 0, "R6 isr empty"); expect_v(K_DLV, 1, "R7 class1 over empty");
    settle();
    ack = 1; tick();
    expect_v(K_TREQ, 0, "R4 empty req top"); expect_v(K_DLV, 0, "R7 empty req");
    expect_v(K_TISR, 8'h1F, "R5 isr 1F");
    settle();
    ack = 1; tick();
    expect_v(K_TISR, 8'h1F, "R5 ack on empty ignored");
    settle();
    rd(1, 0, 32'h8000_0000, "R5 isr word0 after empty ack");
    eoi = 1; tick();
    eoi = 1; tick();
    expect_v(K_TISR, 0, "R6 eoi on empty");
    settle();
    rd(1, 0, 32'h0, "R6 isr word0 empty");

    // R5 vector 0 and R7 class 0
    do_set(8'h00);
    expect_v(K_DLV, 0, "R7 class0 not over empty");
    settle();
    ack = 1; tick();
    settle();
    rd(1, 0, 32'h1, "R5 vector0 in service");
    rd(0, 0, 32'h0, "R5 vector0 left request");
    eoi = 1; tick();
    settle();
    rd(1, 0, 32'h0, "R6 vector0 retired");

    // R8 / R9 special kinds
    sb_raise = 5'b00100; sb_vec = 8'h33; tick();
    expect_v(K_PEND, 5'b00100, "R8 ext pending"); expect_v(K_URG, 0, "R9 ext excluded");
    expect_v(K_EXTV, 8'h33, "R8 ext vector"); expect_v(K_TREQ, 0, "R8 req untouched");
    settle();
    rd(0, 1, 32'h0, "R8 req word1 untouched");
    sb_raise = 5'b00010; sb_vec = 8'h02; tick();
    expect_v(K_URG, 1, "R9 nmi urgent"); expect_v(K_NMIV, 8'h02, "R8 nmi vector");
    settle();
    sb_take = 5'b00110; tick();
    expect_v(K_PEND, 0, "R8 take clears"); expect_v(K_URG, 0, "R9 none pending");
    settle();
    sb_raise = 5'b00001; sb_take = 5'b00001; sb_vec = 8'h11; tick();
    expect_v(K_PEND, 5'b00001, "R8 raise beats take"); expect_v(K_URG, 1, "R9 smi urgent");
    settle();

    // R10 interprocessor count
    for (int i = 0; i < 3; i++) begin ipi_send = 1; tick(); end
    expect_v(K_IPI, 3, "R10 count up");
    settle();
    ipi_send = 1; ipi_done = 1; tick();
    expect_v(K_IPI, 3, "R10 both hold");
    settle();
    for (int i = 0; i < 5; i++) begin ipi_done = 1; tick(); end
    expect_v(K_IPI, 0, "R10 floor");
    settle();
    for (int i = 0; i < 9; i++) begin ipi_send = 1; tick(); end
    expect_v(K_IPI, 7, "R10 ceiling");
    settle();

    settle();
    finished = 1;
    finish_run();
  end
endmodule